// File: doc/BRIEF.md
# System Exception Control Register Block

This block holds the software-visible state of a core's system exceptions: the pending, active and enable flags, the per-exception priorities and the vector table base. The exceptions it tracks are the non-maskable interrupt (2), memory-management fault (4), bus fault (5), usage fault (6), supervisor call (11), debug monitor (12), deferred service call (14) and tick (15). External interrupt n has exception number 16+n. Software reaches the block through word reads and writes on a 12-bit offset bus. The core, the tick timer and an external arbiter drive strobes and summaries into it.

The block does not arbitrate between exceptions. It exports its pending and active vectors and the packed priorities to an arbiter. It takes the highest pending vector back from the arbiter and reports it. Requests to reset or to clear all active flags need a 16-bit key in the upper halfword of the write.

Top module: `sys_exc_ctrl`

## Requirements
- R1: After reset, pend_o, act_o, fault_en_o, prio_o, vtor_o, rdata_o, err_o and rst_req_o are all zero.
- R2: A write to offset 0xD04 affects three flags. Bit 31 sets NMI pending. Bit 28 sets deferred-call pending, and bit 27 clears it only when bit 28 is clear. Bit 26 sets tick pending, and bit 25 clears it only when bit 26 is clear.
- R3: A read of offset 0xD04 returns these fields. Bits [8:0] hold the lowest-numbered active exception, or 0 when none is active. Bit 11 is 1 when at most one exception is active. Bits 12 upward hold pend_vec_i. Bit 22 is ext_pend_i. Bits 26, 28 and 31 hold the tick, deferred-call and NMI pending flags.
- R4: A write to offset 0xD08 stores the write data ANDed with 0xFFFFFF80. The stored value drives vtor_o and reads back at the same offset.
- R5: Offset 0xD0C reads 0x0FA05000. A write there acts only when bits [31:16] equal 0x05FA. With the key, bit 0 or bit 2 gives a one-cycle rst_req_o pulse, and bit 1 clears every active flag. Without the key the write has no effect.
- R6: Offsets 0xD18, 0xD1C and 0xD20 each hold four 8-bit priorities, lowest byte first, for exceptions 4–7, 8–11 and 12–15. prio_o carries exception e in bits [(e-4)*8 +: 8].
- R7: A read of offset 0xD24 returns the following. Active flags appear at bit 0 (mem), 1 (bus), 3 (usage), 7 (supervisor call), 8 (debug), 10 (deferred call) and 11 (tick). Pending flags appear at bit 12 (usage), 13 (mem), 14 (bus) and 15 (supervisor call). Bits 16–18 are the writable enables for mem, bus and usage faults, and fault_en_o carries them as {usage, bus, mem}. Other written bits are ignored.
- R8: Offset 0x004 reads NUM_EXT_IRQ/32 − 1, which is 1 by default. Writes to it are ignored and raise no error.
- R9: A read or write at any offset not named in R2–R8 reads zero and changes no state. err_o is 1 in the cycle after such an access and 0 after that unless the access repeats.
- R10: tick_i sets tick pending. pend_set_i sets pending only for the tracked exceptions. act_set_i sets the active flag of act_vec_i and clears that exception's pending flag. act_clr_i clears the active flag of act_vec_i. When a set and a clear of the same flag fall in one cycle, the set wins.
- R11: rdata_o takes the addressed value in the cycle after rd_en_i and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Word write strobe |
| rd_en_i | input | 1 | Word read strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Access to an unimplemented offset, one cycle later |
| tick_i | input | 1 | Tick timer set-pending strobe |
| pend_set_i | input | 16 | Per-exception set-pending strobes |
| act_set_i | input | 1 | Mark act_vec_i active |
| act_clr_i | input | 1 | Mark act_vec_i inactive |
| act_vec_i | input | 4 | System exception number for the active strobes |
| pend_vec_i | input | VEC_W | Highest pending vector from the arbiter |
| ext_pend_i | input | 1 | Some external interrupt is pending |
| pend_o | output | 16 | Pending flags by exception number |
| act_o | output | 16 | Active flags by exception number |
| fault_en_o | output | 3 | Fault enables {usage, bus, mem} |
| prio_o | output | 12*PRIO_W | Priorities of exceptions 4–15 |
| vtor_o | output | 32 | Vector table base |
| rst_req_o | output | 1 | Keyed reset request pulse |

## Verification
The flag registers feed pend_o and act_o directly, so a lost set or a missed clear shows at those ports on the next cycle. The same wrong state appears in the 0xD04 and 0xD24 readback one read later. A slip in bit placement or in set-over-clear precedence only shows through a read of the affected word. The bench therefore reads the status words back after every combined set/clear pattern. A key comparison that is too loose shows as a stray rst_req_o pulse, or as act_o dropping to zero in the cycle after the unkeyed write.

// File: rtl/sys_exc_pkg.sv
package sys_exc_pkg;
  localparam int unsigned EXC_NMI   = 2;
  localparam int unsigned EXC_MEM   = 4;
  localparam int unsigned EXC_BUS   = 5;
  localparam int unsigned EXC_USAGE = 6;
  localparam int unsigned EXC_SVC   = 11;
  localparam int unsigned EXC_DEBUG = 12;
  localparam int unsigned EXC_DEFER = 14;
  localparam int unsigned EXC_TICK  = 15;

  // exceptions that own pending/active state
  localparam logic [15:0] TRACKED_MASK = 16'hD874;

  localparam logic [11:0] OFS_CTYPE  = 12'h004;
  localparam logic [11:0] OFS_STAT   = 12'hD04;
  localparam logic [11:0] OFS_VBASE  = 12'hD08;
  localparam logic [11:0] OFS_KEYCTL = 12'hD0C;
  localparam logic [11:0] OFS_PRIO0  = 12'hD18;
  localparam logic [11:0] OFS_HSTAT  = 12'hD24;

  localparam logic [15:0] KEY_VAL    = 16'h05FA;
  localparam logic [31:0] KEYCTL_RD  = 32'h0FA05000;
  localparam logic [31:0] VBASE_MASK = 32'hFFFFFF80;

  localparam int unsigned PRIO_WORDS = 3;

  typedef struct packed {
    logic                  ctype;
    logic                  stat;
    logic                  vbase;
    logic                  keyctl;
    logic [PRIO_WORDS-1:0] prio;
    logic                  hstat;
    logic                  bad;
  } sel_t;
endpackage

// File: rtl/sys_exc_decode.sv
module sys_exc_decode
  import sys_exc_pkg::*;
(
  input  logic [11:0] addr_i,
  output sel_t        sel_o
);
  logic [PRIO_WORDS-1:0] prio_hit;

  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio
    assign prio_hit[k] = (addr_i == OFS_PRIO0 + 12'(4 * k));
  end

  always_comb begin
    sel_o       = '0;
    sel_o.ctype  = (addr_i == OFS_CTYPE);
    sel_o.stat   = (addr_i == OFS_STAT);
    sel_o.vbase  = (addr_i == OFS_VBASE);
    sel_o.keyctl = (addr_i == OFS_KEYCTL);
    sel_o.prio   = prio_hit;
    sel_o.hstat  = (addr_i == OFS_HSTAT);
    sel_o.bad    = ~(sel_o.ctype | sel_o.stat | sel_o.vbase | sel_o.keyctl |
                     (|prio_hit) | sel_o.hstat);
  end
endmodule

// File: rtl/sys_exc_state.sv
module sys_exc_state
  import sys_exc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stat_we_i,
  input  logic        hstat_we_i,
  input  logic        clr_all_act_i,
  input  logic [31:0] wdata_i,
  input  logic        tick_i,
  input  logic [15:0] pend_set_i,
  input  logic        act_set_i,
  input  logic        act_clr_i,
  input  logic [3:0]  act_vec_i,
  output logic [15:0] pend_o,
  output logic [15:0] act_o,
  output logic [2:0]  fault_en_o
);
  logic [15:0] pend_q, act_q, set_p, clr_p, set_a, clr_a;
  logic [2:0]  en_q;

  always_comb begin
    set_p = pend_set_i;
    clr_p = '0;
    set_p[EXC_TICK] = set_p[EXC_TICK] | tick_i;
    if (stat_we_i) begin
      set_p[EXC_NMI]   = set_p[EXC_NMI]   | wdata_i[31];
      set_p[EXC_DEFER] = set_p[EXC_DEFER] | wdata_i[28];
      set_p[EXC_TICK]  = set_p[EXC_TICK]  | wdata_i[26];
      clr_p[EXC_DEFER] = wdata_i[27] & ~wdata_i[28];
      clr_p[EXC_TICK]  = wdata_i[25] & ~wdata_i[26];
    end
    set_a = act_set_i ? (16'h1 << act_vec_i) : '0;
    clr_a = clr_all_act_i ? '1 : (act_clr_i ? (16'h1 << act_vec_i) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      en_q   <= '0;
    end else begin
      // sets are applied last so they win over any same-cycle clear
      pend_q <= ((pend_q & ~clr_p & ~set_a) | set_p) & TRACKED_MASK;
      act_q  <= ((act_q & ~clr_a) | set_a) & TRACKED_MASK;
      if (hstat_we_i) en_q <= wdata_i[18:16];
    end
  end

  assign pend_o     = pend_q;
  assign act_o      = act_q;
  assign fault_en_o = en_q;
endmodule

// File: rtl/sys_exc_prio.sv
module sys_exc_prio #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned WORDS  = 3,
  localparam int unsigned SLOTS = 4 * WORDS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [WORDS-1:0]        we_i,
  input  logic [31:0]             wdata_i,
  output logic [SLOTS*PRIO_W-1:0] prio_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      logic [PRIO_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (we_i[w]) q <= wdata_i[b*8 +: PRIO_W];
      end
      assign prio_o[(w*4+b)*PRIO_W +: PRIO_W] = q;
    end
  end
endmodule

// File: rtl/sys_exc_ctrl.sv
module sys_exc_ctrl
  import sys_exc_pkg::*;
#(
  parameter int unsigned NUM_EXT_IRQ = 64,
  parameter int unsigned PRIO_W      = 8,
  localparam int unsigned VEC_W      = $clog2(16 + NUM_EXT_IRQ),
  localparam int unsigned PRIO_BITS  = 4 * PRIO_WORDS * PRIO_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 err_o,
  input  logic                 tick_i,
  input  logic [15:0]          pend_set_i,
  input  logic                 act_set_i,
  input  logic                 act_clr_i,
  input  logic [3:0]           act_vec_i,
  input  logic [VEC_W-1:0]     pend_vec_i,
  input  logic                 ext_pend_i,
  output logic [15:0]          pend_o,
  output logic [15:0]          act_o,
  output logic [2:0]           fault_en_o,
  output logic [PRIO_BITS-1:0] prio_o,
  output logic [31:0]          vtor_o
  ,output logic                rst_req_o
);
  localparam logic [31:0] CTYPE_VAL = 32'(NUM_EXT_IRQ / 32 - 1);

  sel_t        sel;
  logic        key_ok, rst_req_q, err_q;
  logic [31:0] vbase_q, rdata_q, rd_mux, stat_rd, hstat_rd;
  logic [31:0] prio_rd [PRIO_WORDS];
  logic [3:0]  act_low;

  sys_exc_decode u_dec (.addr_i(addr_i), .sel_o(sel));

  assign key_ok = wr_en_i & sel.keyctl & (wdata_i[31:16] == KEY_VAL);

  sys_exc_state u_state (
    .clk_i, .rst_ni,
    .stat_we_i     (wr_en_i & sel.stat),
    .hstat_we_i    (wr_en_i & sel.hstat),
    .clr_all_act_i (key_ok & wdata_i[1]),
    .wdata_i, .tick_i, .pend_set_i, .act_set_i, .act_clr_i, .act_vec_i,
    .pend_o, .act_o, .fault_en_o
  );

  sys_exc_prio #(.PRIO_W(PRIO_W), .WORDS(PRIO_WORDS)) u_prio (
    .clk_i, .rst_ni,
    .we_i    (sel.prio & {PRIO_WORDS{wr_en_i}}),
    .wdata_i,
    .prio_o
  );

  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prd
    for (genvar b = 0; b < 4; b++) begin : g_b
      assign prio_rd[w][b*8 +: 8] = 8'(prio_o[(w*4+b)*PRIO_W +: PRIO_W]);
    end
  end

  always_comb begin
    act_low = '0;
    for (int i = 15; i >= 0; i--) if (act_o[i]) act_low = 4'(i);
  end

  always_comb begin
    stat_rd = '0;
    stat_rd[3:0]           = act_low;
    stat_rd[11]            = ($countones(act_o) <= 1);
    stat_rd[12 +: VEC_W]   = pend_vec_i;
    stat_rd[22]            = ext_pend_i;
    stat_rd[26]            = pend_o[EXC_TICK];
    stat_rd[28]            = pend_o[EXC_DEFER];
    stat_rd[31]            = pend_o[EXC_NMI];

    hstat_rd = '0;
    hstat_rd[0]     = act_o[EXC_MEM];
    hstat_rd[1]     = act_o[EXC_BUS];
    hstat_rd[3]     = act_o[EXC_USAGE];
    hstat_rd[7]     = act_o[EXC_SVC];
    hstat_rd[8]     = act_o[EXC_DEBUG];
    hstat_rd[10]    = act_o[EXC_DEFER];
    hstat_rd[11]    = act_o[EXC_TICK];
    hstat_rd[12]    = pend_o[EXC_USAGE];
    hstat_rd[13]    = pend_o[EXC_MEM];
    hstat_rd[14]    = pend_o[EXC_BUS];
    hstat_rd[15]    = pend_o[EXC_SVC];
    hstat_rd[18:16] = fault_en_o;
  end

  always_comb begin
    rd_mux = '0;
    if (sel.ctype)  rd_mux = CTYPE_VAL;
    if (sel.stat)   rd_mux = stat_rd;
    if (sel.vbase)  rd_mux = vbase_q;
    if (sel.keyctl) rd_mux = KEYCTL_RD;
    if (sel.hstat)  rd_mux = hstat_rd;
    for (int w = 0; w < PRIO_WORDS; w++) if (sel.prio[w]) rd_mux = prio_rd[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbase_q   <= '0;
      rdata_q   <= '0;
      rst_req_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (wr_en_i && sel.vbase) vbase_q <= wdata_i & VBASE_MASK;
      if (rd_en_i) rdata_q <= rd_mux;
      rst_req_q <= key_ok & (wdata_i[0] | wdata_i[2]);
      err_q     <= (wr_en_i | rd_en_i) & sel.bad;
    end
  end

  assign vtor_o    = vbase_q;
  assign rdata_o   = rdata_q;
  assign rst_req_o = rst_req_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sys_exc_ctrl_chk.sv
module sys_exc_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [11:0] addr_i,
  input logic [31:0] wdata_i,
  input logic        err_o,
  input logic        tick_i,
  input logic        act_set_i,
  input logic [15:0] pend_o,
  input logic [15:0] act_o,
  input logic [31:0] vtor_o,
  input logic        rst_req_o
);
  a_r10_tick_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> pend_o[15]);

  a_r5_rst_req_keyed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wr_en_i && addr_i == 12'hD0C && wdata_i[31:16] == 16'h05FA));

  a_r5_clear_all_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 12'hD0C && wdata_i[31:16] == 16'h05FA && wdata_i[1] && !act_set_i)
    |=> (act_o == 16'h0));

  a_r4_vtor_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vtor_o) |-> $past(wr_en_i && addr_i == 12'hD08));

  a_r9_err_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i || rd_en_i));
endmodule

bind sys_exc_ctrl sys_exc_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .err_o(err_o), .tick_i(tick_i),
  .act_set_i(act_set_i), .pend_o(pend_o), .act_o(act_o), .vtor_o(vtor_o),
  .rst_req_o(rst_req_o)
);

// File: tb/sys_exc_ctrl_bench.sv
module sys_exc_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, rd_en = 0, tick = 0, act_set = 0, act_clr = 0, ext_pend = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pend_set = '0;
  logic [3:0]  act_vec = '0;
  logic [6:0]  pend_vec = '0;
  logic [31:0] rdata, vtor;
  logic [15:0] pend, act;
  logic [2:0]  fen;
  logic [95:0] prio;
  logic        err, rst_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sys_exc_ctrl u_sys_exc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .tick_i(tick), .pend_set_i(pend_set),
    .act_set_i(act_set), .act_clr_i(act_clr), .act_vec_i(act_vec), .pend_vec_i(pend_vec),
    .ext_pend_i(ext_pend), .pend_o(pend), .act_o(act), .fault_en_o(fen), .prio_o(prio),
    .vtor_o(vtor), .rst_req_o(rst_req)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h004, 32'h0, 32'h0000_0001, 4'd8},          // R8
    '{1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0, 4'd8},           // R8 write ignored
    '{1'b0, 12'h004, 32'h0, 32'h0000_0001, 4'd8},
    '{1'b1, 12'hD08, 32'h1234_5FFF, 32'h0, 4'd4},           // R4
    '{1'b0, 12'hD08, 32'h0, 32'h1234_5F80, 4'd4},
    '{1'b1, 12'hD18, 32'h4433_2211, 32'h0, 4'd6},           // R6
    '{1'b1, 12'hD1C, 32'hA0B0_C0D0, 32'h0, 4'd6},
    '{1'b1, 12'hD20, 32'h0102_0304, 32'h0, 4'd6},
    '{1'b0, 12'hD18, 32'h0, 32'h4433_2211, 4'd6},
    '{1'b0, 12'hD1C, 32'h0, 32'hA0B0_C0D0, 4'd6},
    '{1'b0, 12'hD20, 32'h0, 32'h0102_0304, 4'd6},
    '{1'b0, 12'hD0C, 32'h0, 32'h0FA0_5000, 4'd5},           // R5
    '{1'b1, 12'hD24, 32'hFFFF_FFFF, 32'h0, 4'd7},           // R7
    '{1'b0, 12'hD24, 32'h0, 32'h0007_0000, 4'd7},
    '{1'b1, 12'hD04, 32'h9400_0000, 32'h0, 4'd2},           // R2 set three
    '{1'b0, 12'hD04, 32'h0, 32'h9400_0800, 4'd3},           // R3
    '{1'b1, 12'hD04, 32'h0A00_0000, 32'h0, 4'd2},           // R2 clears
    '{1'b0, 12'hD04, 32'h0, 32'h8000_0800, 4'd2}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic act_strobe(logic set, logic [3:0] v);
    @(negedge clk); act_set = set; act_clr = ~set; act_vec = v;
    @(negedge clk); act_set = 0; act_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pend", 32'(pend), 0); chk("R1 act", 32'(act), 0);
    chk("R1 vtor", vtor, 0); chk("R1 prio", 32'(|prio), 0);
    chk("R1 fen", 32'(fen), 0); chk("R1 rdata", rdata, 0);
    chk("R1 err/rst", {30'b0, err, rst_req}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
      else begin
        rd(TBL[i].addr);
        chk($sformatf("R%0d table %0d", TBL[i].req, i), rdata, TBL[i].exp);
      end
    end

    // R6 priority output packing, R4 vtor port, R7 enables port
    chk("R6 prio exc4", 32'(prio[7:0]), 32'h11);
    chk("R6 prio exc9", 32'(prio[47:40]), 32'hC0);
    chk("R6 prio exc15", 32'(prio[95:88]), 32'h01);
    chk("R4 vtor_o", vtor, 32'h1234_5F80);
    chk("R7 fault_en_o", 32'(fen), 32'h7);

    // R2 set wins over clear when both bits given
    wr(12'hD04, 32'h1E00_0000);
    rd(12'hD04); chk("R2 set beats clear", rdata, 32'h9400_0800);
    wr(12'hD04, 32'h0A00_0000);
    chk("R2 pend after clear", 32'(pend), 32'h0004);

    // R9 unimplemented offsets
    @(negedge clk); rd_en = 1; addr = 12'hD00;
    @(negedge clk); rd_en = 0;
    chk("R9 read zero", rdata, 0);
    chk("R9 err pulse", 32'(err), 1);
    @(negedge clk); chk("R9 err one cycle", 32'(err), 0);
    wr(12'hD40, 32'hFFFF_FFFF);
    chk("R9 write err", 32'(err), 1);
    chk("R9 write no effect", 32'(pend), 32'h0004);
    rd(12'hD10); chk("R9 read D10", rdata, 0);

    // R10 hardware strobes
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk("R10 tick pend", 32'(pend), 32'h8004);
    act_strobe(1, 4'd15);
    chk("R10 activate", 32'(act), 32'h8000);
    chk("R10 activate clears pend", 32'(pend), 32'h0004);
    pend_vec = 7'd40; ext_pend = 1;
    rd(12'hD04); chk("R3 one active", rdata, 32'h8042_880F);
    pend_vec = 0; ext_pend = 0;
    act_strobe(1, 4'd4);
    rd(12'hD04); chk("R3 two active", rdata, 32'h8000_0004);
    @(negedge clk); pend_set = 16'h00C0;
    @(negedge clk); pend_set = 0;
    chk("R10 untracked ignored", 32'(pend), 32'h0044);
    rd(12'hD24); chk("R7 status bits", rdata, 32'h0007_1801);
    act_strobe(0, 4'd4);
    chk("R10 deactivate", 32'(act), 32'h8000);
    @(negedge clk); wr_en = 1; addr = 12'hD04; wdata = 32'h0200_0000; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    chk("R10 set beats clear", 32'(pend[15]), 1);

    // R11 read data holds
    rd(12'hD08);
    @(negedge clk); addr = 12'hD0C;
    @(negedge clk);
    chk("R11 hold", rdata, 32'h1234_5F80);
    wr(12'hD08, 32'h0000_0100);
    chk("R11 hold after write", rdata, 32'h1234_5F80);

    // R5 keyed control
    act_strobe(1, 4'd5);
    wr(12'hD0C, 32'h0000_0007);
    chk("R5 no key no reset", 32'(rst_req), 0);
    chk("R5 no key no clear", 32'(act), 32'h8020);
    wr(12'hD0C, 32'h05FA_0002);
    chk("R5 clear active", 32'(act), 0);
    chk("R5 no reset on clear", 32'(rst_req), 0);
    wr(12'hD0C, 32'h05FA_0001);
    chk("R5 reset bit0", 32'(rst_req), 1);
    @(negedge clk); chk("R5 reset pulse ends", 32'(rst_req), 0);
    wr(12'hD0C, 32'h05FA_0004);
    chk("R5 reset bit2", 32'(rst_req), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule